// File: doc/BRIEF.md
# CPU/Video Memory Access Sequencer

This block lets an 8-bit CPU and a video fetch engine share one single-port memory. Time is divided into groups of four master-clock cycles. Each group gives one access slot to the CPU and one to the video engine, so the two never compete for the memory and no arbitration is needed. The same phase counter produces the CPU clock and a one-cycle clock enable. Each group of four master cycles is one CPU T-state.

The sequencer keeps the CPU in step with the video fetch rate. It stretches every opcode fetch with wait states so that the fetch always finishes on the last T-state of a four-T-state group. It adds exactly one wait state to every CPU memory write. It also decodes a small memory map. A read from the bottom 16 KiB comes from a low ROM, and a read from the top 16 KiB comes from a high ROM, but only while the matching enable input is high. Every other read comes from RAM, and every write goes to RAM. I/O writes are dropped and I/O reads return zero.

The video engine reads the top 16 KiB of RAM as 16-bit words. It fetches one word every four T-states, starting at the bottom of that window and wrapping back to it after the last word.

Top module: `cpu_video_arbiter`

## Requirements
- R1: After reset the phase starts at 0 and counts 0,1,2,3 repeatedly, one step per master clock. `cpuClk` equals phase bit 1. `cpuClkEn` is high only in phase 1, which marks the end of one T-state.
- R2: A CPU memory request is issued only in phase 0. A video request is issued only in phase 2, and only when the free-running T-state counter (T-states since reset, modulo 4) is 0. `memReq` is never high in phases 1 or 3.
- R3: A CPU memory read is routed as follows. Address bits 15:14 = 00 with `loRomEn` high selects `memRegion` 01 (low ROM). Bits 15:14 = 11 with `hiRomEn` high selects `memRegion` 10 (high ROM). Every other read selects 00 (RAM). `memAddr` is CPU address bits 15:1.
- R4: A CPU memory write always uses `memRegion` 00 with `memWe` high, whatever the ROM enables are. `memBe` is 01 for an even address and 10 for an odd address, and `memWdata` carries the data byte in both halves.
- R5: An I/O cycle (`iorqN` low, `mreqN` high) issues no memory request. An I/O read returns 0x00 on `cpuDin`.
- R6: Read data is registered at the end of phase 1 of the read T-state. `cpuDin` is the high byte of the returned word for an odd address and the low byte for an even address, and it holds its value until the next read.
- R7: Video fetches read RAM (`memRegion` 00, `memBe` 11). They start at word address 0x6000 (byte 0xC000) and step by one word per fetch, wrapping from 0x7FFF back to 0x6000. `vidValid` is high for one cycle right after the fetched word appears on `vidData`, and fetches come every 16 master cycles.
- R8: During an opcode fetch (`m1N` and `mreqN` low), `waitN` is held low in the second T-state until the T-state counter equals 1. The fetch's last T-state therefore has counter value 3.
- R9: After the first opcode fetch, each CPU memory write (`mreqN` and `wrN` low) sees `waitN` low for exactly one T-state.
- R10: Reset leaves `waitN` high, `cpuDin` at zero and the video pointer at 0x6000. Before the first opcode fetch no write is stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address bus |
| cpuDout | input | 8 | CPU write data |
| m1N | input | 1 | Opcode fetch cycle, active low |
| mreqN | input | 1 | Memory cycle, active low |
| iorqN | input | 1 | I/O cycle, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| loRomEn | input | 1 | Low ROM visible to reads |
| hiRomEn | input | 1 | High ROM visible to reads |
| cpuDin | output | 8 | Data returned to CPU |
| waitN | output | 1 | Wait request, active low |
| cpuClk | output | 1 | CPU clock (phase bit 1) |
| cpuClkEn | output | 1 | One-cycle T-state advance enable |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memRegion | output | 2 | 00 RAM, 01 low ROM, 10 high ROM |
| memAddr | output | 15 | Word address |
| memBe | output | 2 | Byte enables |
| memWdata | output | 16 | Write word |
| memRdata | input | 16 | Read word, valid one cycle after request |
| vidData | output | 16 | Fetched video word |
| vidValid | output | 1 | New video word strobe |

## Verification
The assertions check these properties on every cycle:
- the clock enable lasts a single cycle and comes just before the CPU clock rises;
- an opcode fetch leaves its second T-state only when the counter has reached its alignment value;
- a write's wait flag is set only after a low `waitN`;
- writes never leave RAM, and I/O cycles issue no requests;
- the video pointer stays inside its window, and every video strobe follows a full-word RAM read two cycles earlier.

Some behaviour can only be shown by the bench's scenarios:
- the number of wait states for each of the four starting alignments of an opcode fetch;
- the single write wait after a fetch, and its absence before the first fetch;
- the ROM and RAM routing under the different enable combinations;
- the byte selection of read data;
- the full sweep of the video window and its wrap.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Physical region selected for a memory access
  typedef enum logic [1:0] {
    REG_RAM   = 2'b00,
    REG_LOROM = 2'b01,
    REG_HIROM = 2'b10
  } regionT;

  // Slot timing strobes from control to datapath
  typedef struct packed {
    logic cpuIssue;    // phase 0: drive CPU request
    logic cpuCapture;  // phase 1: register CPU read data
    logic vidIssue;    // phase 2 of a fetch T-state: drive video request
    logic vidCapture;  // phase 3 of a fetch T-state: register video word
  } seqStrobeT;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int TGRP_W = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      m1N,
  input  logic      mreqN,
  input  logic      wrN,
  output logic      cpuClk,
  output logic      cpuClkEn,
  output logic      waitN,
  output seqStrobeT strb
);

  localparam int PHASE_W = 2;
  localparam int TGROUP  = 1 << TGRP_W;
  localparam logic [PHASE_W-1:0] PH_CPU_GO  = PHASE_W'(0);
  localparam logic [PHASE_W-1:0] PH_CPU_END = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] PH_VID_GO  = PHASE_W'(2);
  localparam logic [PHASE_W-1:0] PH_VID_END = PHASE_W'(3);
  // The fetch leaves T2 at this count so that T3/T4 close the group
  localparam logic [TGRP_W-1:0] ALIGN_T    = TGRP_W'(TGROUP - 3);
  localparam logic [TGRP_W-1:0] ALIGN_NEXT = TGRP_W'(TGROUP - 2);
  localparam logic [TGRP_W-1:0] FETCH_T    = '0;

  logic [PHASE_W-1:0] phase;
  logic [TGRP_W-1:0]  tCnt;
  logic [1:0]         m1Idx;
  logic               seenM1;
  logic               wrWaitDone;
  logic               cpuWrAct;
  logic               m1Hold;
  logic               wrHold;

  assign cpuWrAct = !mreqN && !wrN;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_CPU_GO;
    else       phase <= phase + 1'b1;
  end

  assign cpuClk   = phase[PHASE_W-1];
  assign cpuClkEn = (phase == PH_CPU_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tCnt       <= '0;
      m1Idx      <= 2'd0;
      seenM1     <= 1'b0;
      wrWaitDone <= 1'b0;
    end else if (cpuClkEn) begin
      tCnt <= tCnt + 1'b1;
      if (m1N)                        m1Idx <= 2'd0;
      else if (waitN && m1Idx != 2'd3) m1Idx <= m1Idx + 2'd1;
      if (!m1N) seenM1 <= 1'b1;
      if (cpuWrAct) wrWaitDone <= wrWaitDone | !waitN;
      else          wrWaitDone <= 1'b0;
    end
  end

  always_comb begin
    m1Hold = !m1N && !mreqN && (m1Idx == 2'd1) && (tCnt != ALIGN_T);
    wrHold = seenM1 && cpuWrAct && !wrWaitDone;
    waitN  = !(m1Hold || wrHold);
  end

  always_comb begin
    strb.cpuIssue   = (phase == PH_CPU_GO);
    strb.cpuCapture = (phase == PH_CPU_END);
    strb.vidIssue   = (phase == PH_VID_GO)  && (tCnt == FETCH_T);
    strb.vidCapture = (phase == PH_VID_END) && (tCnt == FETCH_T);
  end

  // R1
  en_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |=> !cpuClkEn);

  // R1
  clk_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClk) |-> $past(cpuClkEn));

  // R8
  m1_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (m1Idx == 2'd2 && $past(m1Idx) == 2'd1) |-> tCnt == ALIGN_NEXT);

  // R9
  wr_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrWaitDone) |-> $past(!waitN));

  // R10
  no_early_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenM1 |-> waitN);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VID_BASE = 16'hC000
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobeT           strb,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuDout,
  input  logic                mreqN,
  input  logic                iorqN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic                loRomEn,
  input  logic                hiRomEn,
  input  logic [2*DATA_W-1:0] memRdata,
  output logic                memReq,
  output logic                memWe,
  output logic [1:0]          memRegion,
  output logic [ADDR_W-2:0]   memAddr,
  output logic [1:0]          memBe,
  output logic [2*DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0]   cpuDin,
  output logic [2*DATA_W-1:0] vidData,
  output logic                vidValid
);

  localparam int WADDR_W = ADDR_W - 1;
  localparam logic [WADDR_W-1:0] VID_FIRST = VID_BASE[ADDR_W-1:1];
  localparam logic [WADDR_W-1:0] VID_LAST  = {WADDR_W{1'b1}};
  localparam logic [1:0] TOP_LOW  = 2'b00;
  localparam logic [1:0] TOP_HIGH = 2'b11;

  logic         cpuMemRd;
  logic         cpuMemWr;
  logic         ioRd;
  logic [1:0]   topBits;
  regionT       cpuRegion;
  logic [WADDR_W-1:0] vidPtr;

  assign cpuMemRd = !mreqN && !rdN;
  assign cpuMemWr = !mreqN && !wrN;
  assign ioRd     = !iorqN && !rdN;
  assign topBits  = cpuAddr[ADDR_W-1 -: 2];

  always_comb begin
    cpuRegion = REG_RAM;
    if (!cpuMemWr) begin
      if (topBits == TOP_LOW && loRomEn)       cpuRegion = REG_LOROM;
      else if (topBits == TOP_HIGH && hiRomEn) cpuRegion = REG_HIROM;
    end
  end

  always_comb begin
    memReq    = 1'b0;
    memWe     = 1'b0;
    memRegion = REG_RAM;
    memAddr   = '0;
    memBe     = 2'b00;
    memWdata  = '0;
    if (strb.cpuIssue && (cpuMemRd || cpuMemWr)) begin
      memReq    = 1'b1;
      memWe     = cpuMemWr;
      memRegion = cpuRegion;
      memAddr   = cpuAddr[ADDR_W-1:1];
      memBe     = cpuMemWr ? (cpuAddr[0] ? 2'b10 : 2'b01) : 2'b11;
      memWdata  = {cpuDout, cpuDout};
    end else if (strb.vidIssue) begin
      memReq    = 1'b1;
      memRegion = REG_RAM;
      memAddr   = vidPtr;
      memBe     = 2'b11;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuDin <= '0;
    end else if (strb.cpuCapture) begin
      if (cpuMemRd)  cpuDin <= cpuAddr[0] ? memRdata[2*DATA_W-1:DATA_W]
                                          : memRdata[DATA_W-1:0];
      else if (ioRd) cpuDin <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidPtr   <= VID_FIRST;
      vidData  <= '0;
      vidValid <= 1'b0;
    end else begin
      vidValid <= strb.vidCapture;
      if (strb.vidCapture) begin
        vidData <= memRdata;
        vidPtr  <= (vidPtr == VID_LAST) ? VID_FIRST : vidPtr + 1'b1;
      end
    end
  end

  // R4
  wr_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memRegion == REG_RAM);

  // R5
  io_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!iorqN && mreqN) |-> (!memReq || strb.vidIssue));

  // R7
  vid_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    vidPtr >= VID_FIRST);

  // R7
  vid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    vidValid |-> $past(memReq && memRegion == REG_RAM && memBe == 2'b11 && !memWe, 2));

endmodule

// File: rtl/cpu_video_arbiter.sv
module cpu_video_arbiter
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuDout,
  input  logic        m1N,
  input  logic        mreqN,
  input  logic        iorqN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        loRomEn,
  input  logic        hiRomEn,
  output logic [7:0]  cpuDin,
  output logic        waitN,
  output logic        cpuClk,
  output logic        cpuClkEn,
  output logic        memReq,
  output logic        memWe,
  output logic [1:0]  memRegion,
  output logic [14:0] memAddr,
  output logic [1:0]  memBe,
  output logic [15:0] memWdata,
  input  logic [15:0] memRdata,
  output logic [15:0] vidData,
  output logic        vidValid
);

  seqStrobeT strb;

  seq_ctrl #(.TGRP_W(2)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .m1N      (m1N),
    .mreqN    (mreqN),
    .wrN      (wrN),
    .cpuClk   (cpuClk),
    .cpuClkEn (cpuClkEn),
    .waitN    (waitN),
    .strb     (strb)
  );

  seq_datapath #(.ADDR_W(16), .DATA_W(8), .VID_BASE(16'hC000)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuDout   (cpuDout),
    .mreqN     (mreqN),
    .iorqN     (iorqN),
    .rdN       (rdN),
    .wrN       (wrN),
    .loRomEn   (loRomEn),
    .hiRomEn   (hiRomEn),
    .memRdata  (memRdata),
    .memReq    (memReq),
    .memWe     (memWe),
    .memRegion (memRegion),
    .memAddr   (memAddr),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .cpuDin    (cpuDin),
    .vidData   (vidData),
    .vidValid  (vidValid)
  );

endmodule

// File: tb/cpu_video_arbiter_test.sv
`timescale 1ns/1ps
module cpu_video_arbiter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuDout = 8'h00;
  logic        m1N = 1'b1, mreqN = 1'b1, iorqN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic        loRomEn = 1'b0, hiRomEn = 1'b0;
  logic [15:0] memRdata = 16'h0000;
  logic [7:0]  cpuDin;
  logic        waitN, cpuClk, cpuClkEn, memReq, memWe, vidValid;
  logic [1:0]  memRegion, memBe;
  logic [14:0] memAddr;
  logic [15:0] memWdata, vidData;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int stray = 0;
  bit finished = 0;
  bit reqSeen = 0;
  logic [1:0]  reqRegion, reqBe;
  logic [14:0] reqAddr;
  logic        reqWe;
  logic [15:0] reqWdata;

  always #2.5 clk = ~clk;

  cpu_video_arbiter uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDout(cpuDout),
    .m1N(m1N), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN),
    .loRomEn(loRomEn), .hiRomEn(hiRomEn), .cpuDin(cpuDin), .waitN(waitN),
    .cpuClk(cpuClk), .cpuClkEn(cpuClkEn), .memReq(memReq), .memWe(memWe),
    .memRegion(memRegion), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .vidData(vidData),
    .vidValid(vidValid)
  );

  function automatic logic [15:0] memVal(logic [1:0] r, logic [14:0] a);
    return {a[7:0] ^ 8'hA5, r, a[13:8]};
  endfunction

  // T-state counter value in effect during master cycle c
  function automatic int tOf(int c);
    return ((c + 2) / 4) % 4;
  endfunction

  // Memory model: word valid one cycle after request
  always @(posedge clk) begin
    if (memReq && !memWe) memRdata <= memVal(memRegion, memAddr);
    if (!rstN) cyc = 0;
    else       cyc = cyc + 1;
  end

  // Request observer
  always @(negedge clk) begin
    if (rstN && memReq) begin
      if ((cyc % 4) == 1 || (cyc % 4) == 3) stray++;
      if ((cyc % 4) == 2 && tOf(cyc) != 0) stray++;
      if ((cyc % 4) == 0) begin
        reqSeen   = 1;
        reqRegion = memRegion;
        reqAddr   = memAddr;
        reqWe     = memWe;
        reqBe     = memBe;
        reqWdata  = memWdata;
      end
    end
  end

  task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(output logic w, output int t);
    do @(negedge clk); while (!cpuClkEn);
    w = waitN;
    t = tOf(cyc);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    logic w; int t;
    m1N = 1; mreqN = 1; iorqN = 1; rdN = 1; wrN = 1;
    tick(w, t);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d, output int waits);
    logic w; int t;
    waits = 0;
    reqSeen = 0;
    cpuAddr = a; cpuDout = d; mreqN = 0; wrN = 0;
    do begin
      tick(w, t);
      if (!w) waits++;
    end while (!w && waits < 8);
    idle();
  endtask

  task automatic doRead(input logic [15:0] a);
    logic w; int t;
    reqSeen = 0;
    cpuAddr = a; mreqN = 0; rdN = 0;
    tick(w, t);
    mreqN = 1; rdN = 1;
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    chk("R10 waitN after reset", waitN == 1'b1, waitN, 1);
    chk("R10 cpuDin after reset", cpuDin == 8'h00, cpuDin, 0);
    chk("R1 no enable in phase 0", cpuClkEn == 1'b0, cpuClkEn, 0);
    chk("R2 no request in phase 0 idle", memReq == 1'b0, memReq, 0);
    chk("R7 no video strobe after reset", vidValid == 1'b0, vidValid, 0);
  endtask

  task automatic testPhases();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 enable only in phase 1", cpuClkEn == ((cyc % 4) == 1), cpuClkEn, (cyc % 4) == 1);
      chk("R1 cpuClk is phase bit 1", cpuClk == ((cyc % 4) >= 2), cpuClk, (cyc % 4) >= 2);
    end
  endtask

  task automatic testEarlyWrite();
    int waits;
    idle();
    doWrite(16'h4002, 8'h3C, waits);
    chk("R10 no write wait before first fetch", waits == 0, waits, 0);
    chk("R4 write request seen", reqSeen && reqWe, reqSeen, 1);
  endtask

  task automatic testM1();
    logic w; int t; int waits; int tExit;
    for (int s = 0; s < 4; s++) begin
      idle();
      while (tOf(cyc) != 0) idle();
      for (int k = 0; k < s; k++) idle();
      cpuAddr = 16'h0100 + 16'(s); m1N = 0; mreqN = 0; rdN = 0;
      tick(w, t);
      chk("R8 no wait in first fetch T-state", w == 1'b1, w, 1);
      waits = 0;
      do begin
        tick(w, tExit);
        if (!w) waits++;
      end while (!w && waits < 8);
      chk("R8 fetch wait count", waits == (4 - s) % 4, waits, (4 - s) % 4);
      chk("R8 second T-state exits at count 1", tExit == 1, tExit, 1);
      tick(w, t);
      tick(w, t);
      chk("R8 fetch ends at group boundary", t == 3, t, 3);
      m1N = 1; mreqN = 1; rdN = 1;
    end
  endtask

  task automatic testWrites();
    int waits;
    loRomEn = 1; hiRomEn = 1;
    idle();
    doWrite(16'h0010, 8'h5A, waits);
    chk("R9 one write wait", waits == 1, waits, 1);
    chk("R4 write goes to RAM", reqRegion == 2'b00, reqRegion, 0);
    chk("R4 even byte enable", reqBe == 2'b01, reqBe, 2'b01);
    chk("R4 write data", reqWdata == 16'h5A5A, reqWdata, 16'h5A5A);
    chk("R4 word address", reqAddr == 15'h0008, reqAddr, 15'h0008);
    doWrite(16'hC123, 8'hE7, waits);
    chk("R9 one write wait second", waits == 1, waits, 1);
    chk("R4 odd byte enable", reqBe == 2'b10, reqBe, 2'b10);
    chk("R4 high write to RAM", reqRegion == 2'b00, reqRegion, 0);
  endtask

  task automatic readCase(input string tag, input logic [15:0] a, input logic lo,
                          input logic hi, input logic [1:0] expReg);
    logic [15:0] word;
    logic [7:0]  expB;
    loRomEn = lo; hiRomEn = hi;
    doRead(a);
    word = memVal(expReg, a[15:1]);
    expB = a[0] ? word[15:8] : word[7:0];
    chk({"R3 region ", tag}, reqSeen && reqRegion == expReg && !reqWe, reqRegion, expReg);
    chk({"R3 address ", tag}, reqAddr == a[15:1], reqAddr, a[15:1]);
    chk({"R6 data ", tag}, cpuDin == expB, cpuDin, expB);
    idle();
    chk({"R6 data held ", tag}, cpuDin == expB, cpuDin, expB);
  endtask

  task automatic testReads();
    idle();
    readCase("low rom", 16'h0123, 1, 0, 2'b01);
    readCase("low ram", 16'h0124, 0, 1, 2'b00);
    readCase("high rom", 16'hC456, 0, 1, 2'b10);
    readCase("high ram", 16'hC457, 1, 0, 2'b00);
    readCase("mid ram", 16'h4001, 1, 1, 2'b00);
  endtask

  task automatic testIo();
    logic w; int t;
    loRomEn = 0; hiRomEn = 0;
    idle();
    doRead(16'h8003);
    chk("R6 nonzero before io", cpuDin != 8'h00, cpuDin, 1);
    reqSeen = 0;
    cpuAddr = 16'hCAFE; iorqN = 0; rdN = 0;
    tick(w, t);
    iorqN = 1; rdN = 1;
    chk("R5 io read returns zero", cpuDin == 8'h00, cpuDin, 0);
    chk("R5 io read no request", reqSeen == 0, reqSeen, 0);
    reqSeen = 0;
    cpuDout = 8'h77; iorqN = 0; wrN = 0;
    tick(w, t);
    iorqN = 1; wrN = 1;
    chk("R5 io write no request", reqSeen == 0, reqSeen, 0);
    chk("R5 io write no wait", w == 1'b1, w, 1);
  endtask

  task automatic testVideo();
    int n; int bad = 0; bit firstDone = 0; bit wrapped = 0;
    logic [14:0] ea;
    idle();
    while (!wrapped) begin
      @(negedge clk);
      if (vidValid) begin
        n  = (cyc - 16) / 16;
        ea = 15'(24576 + (n % 8192));
        if (((cyc - 16) % 16) != 0 || vidData != memVal(2'b00, ea)) bad++;
        if (!firstDone) begin
          firstDone = 1;
          chk("R7 fetch spacing", ((cyc - 16) % 16) == 0, cyc, 0);
          chk("R7 fetched word", vidData == memVal(2'b00, ea), vidData, memVal(2'b00, ea));
        end
        if ((n % 8192) == 8191)
          chk("R7 last window word", vidData == memVal(2'b00, 15'h7FFF), vidData,
              memVal(2'b00, 15'h7FFF));
        if (n >= 8192 && (n % 8192) == 0) begin
          chk("R7 wrap to window base", vidData == memVal(2'b00, 15'h6000), vidData,
              memVal(2'b00, 15'h6000));
          wrapped = 1;
        end
      end
    end
    chk("R7 all fetches in order", bad == 0, bad, 0);
    chk("R2 no request outside slots", stray == 0, stray, 0);
  endtask

  initial begin
    #(190000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testPhases();
    testEarlyWrite();
    testM1();
    testWrites();
    testReads();
    testIo();
    testVideo();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule